// File: doc/BRIEF.md
# Page Table Walk Translation Unit

This block turns a 14-bit virtual address into a 12-bit physical address by reading one entry from a single-level page table in memory. Pages are 64 bytes, so the upper eight address bits select one of 256 entries and the low six bits are carried straight into the physical address. The caller supplies the per-process table base together with each request, plus the access kind (read or write) and whether the access runs in supervisor mode.

After a request is taken, the unit issues exactly one read on a simple memory port at the entry's address and waits for the data. It then decodes the entry, checks its presence bit and its permission bits against the access, and returns a response. The response carries either a physical address or a fault class, along with the page number that was translated. Only one walk is in flight at a time. Choosing victims, moving pages and retrying the access are left to software. A translation cache, if present, sits outside this block.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it, `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_req_o` is 0.
- R2: A request is taken only in the idle state (`req_valid_i && req_ready_o` at a clock edge). `req_ready_o` stays 0 from that edge until the response handshake completes. Input requests held during a walk are not taken.
- R3: Each accepted request produces exactly one `mem_req_o` pulse, one cycle long. Its `mem_addr_o` equals `base_i + 2*VA[13:6]`, using the base sampled with the request.
- R4: An entry whose bit 6 (present) is 0 gives `rsp_fault_o = 2'b01`, `rsp_pa_o = 0` and `rsp_vpn_o = VA[13:6]`.
- R5: A non-supervisor access (`req_sup_i = 0`) to a present entry with bit 9 (supervisor-only) set gives `rsp_fault_o = 2'b10` and `rsp_pa_o = 0`.
- R6: A write to a present entry with bit 8 (writable) clear, or a read of a present entry with bit 7 (readable) clear, gives `rsp_fault_o = 2'b10` and `rsp_pa_o = 0`.
- R7: The not-present class takes priority: an entry with bit 6 clear reports 2'b01 whatever its permission bits are.
- R8: A permitted access gives `rsp_fault_o = 2'b00` and `rsp_pa_o = {entry[5:0], VA[5:0]}`.
- R9: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response fields hold steady. A new request is accepted in the cycle after the response handshake.
- R10: A `mem_rvalid_i` pulse while no walk is waiting for data has no effect: no response and no memory read follow.
- R11: Entry bits 15:10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Unit idle and able to take a request |
| req_va_i | input | 14 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_sup_i | input | 1 | 1 = supervisor mode access |
| base_i | input | 16 | Page table base byte address |
| mem_req_o | output | 1 | Memory read strobe, one cycle |
| mem_addr_o | output | 16 | Byte address of the table entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Table entry: [9] supervisor-only, [8] writable, [7] readable, [6] present, [5:0] physical page |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_pa_o | output | 12 | Physical address, 0 on a fault |
| rsp_fault_o | output | 2 | 00 ok, 01 not present, 10 protection |
| rsp_vpn_o | output | 8 | Virtual page number of the request |

## Verification
The presence check and the permission check act on the same fetched entry, so both can trigger in one cycle. The bench provokes this with entries that are absent yet carry supervisor-only or write-protected bits, reached by user-mode writes. It judges that only the not-present class comes out, with a zero address. A second overlap involves response release and a new request: the bench holds a request high across the response handshake. It then checks that exactly one further read is issued, and only after the handshake.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned VA_W     = 14;
  localparam int unsigned PA_W     = 12;
  localparam int unsigned OFF_W    = 6;
  localparam int unsigned PTE_W    = 16;
  localparam int unsigned MEM_AW   = 16;
  localparam int unsigned VPN_W    = VA_W - OFF_W;
  localparam int unsigned PPN_W    = PA_W - OFF_W;

  // entry bit positions
  localparam int unsigned BIT_VLD  = PPN_W;
  localparam int unsigned BIT_RD   = PPN_W + 1;
  localparam int unsigned BIT_WR   = PPN_W + 2;
  localparam int unsigned BIT_SUP  = PPN_W + 3;

  typedef enum logic [1:0] {
    FLT_OK   = 2'b00,
    FLT_ABS  = 2'b01,
    FLT_PROT = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/pte_addr_gen.sv
module pte_addr_gen #(
  parameter int unsigned VPN_W  = 8,
  parameter int unsigned AW     = 16,
  parameter int unsigned PTE_W  = 16
) (
  input  logic [AW-1:0]    base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [AW-1:0]    addr_o
);
  localparam int unsigned PTE_BYTES = PTE_W / 8;
  localparam int unsigned SHIFT     = $clog2(PTE_BYTES);

  logic [AW-1:0] idx_ext;
  assign idx_ext = AW'(vpn_i) << SHIFT;
  assign addr_o  = base_i + idx_ext;
endmodule

// File: rtl/pte_check.sv
module pte_check
  import pt_walker_pkg::*;
#(
  parameter int unsigned EW  = 16,
  parameter int unsigned PW  = 6,
  parameter int unsigned OW  = 6
) (
  input  logic [EW-1:0]    pte_i,
  input  logic             write_i,
  input  logic             sup_i,
  input  logic [OW-1:0]    off_i,
  output fault_e           fault_o,
  output logic [PW+OW-1:0] pa_o
);
  logic vld, rd_ok, wr_ok, sup_only, viol;

  assign vld      = pte_i[PW];
  assign rd_ok    = pte_i[PW+1];
  assign wr_ok    = pte_i[PW+2];
  assign sup_only = pte_i[PW+3];

  assign viol = (sup_only && !sup_i) || (write_i ? !wr_ok : !rd_ok);

  always_comb begin
    if (!vld) begin
      fault_o = FLT_ABS;
      pa_o    = '0;
    end else if (viol) begin
      fault_o = FLT_PROT;
      pa_o    = '0;
    end else begin
      fault_o = FLT_OK;
      pa_o    = {pte_i[PW-1:0], off_i};
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VAW  = VA_W,
  parameter int unsigned PAW  = PA_W,
  parameter int unsigned OW   = OFF_W,
  parameter int unsigned EW   = PTE_W,
  parameter int unsigned AW   = MEM_AW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [VAW-1:0]      req_va_i,
  input  logic                req_write_i,
  input  logic                req_sup_i,
  input  logic [AW-1:0]       base_i,
  output logic                mem_req_o,
  output logic [AW-1:0]       mem_addr_o,
  input  logic                mem_rvalid_i,
  input  logic [EW-1:0]       mem_rdata_i,
  output logic                rsp_valid_o,
  input  logic                rsp_ready_i,
  output logic [PAW-1:0]      rsp_pa_o,
  output logic [1:0]          rsp_fault_o,
  output logic [VAW-OW-1:0]   rsp_vpn_o
);
  localparam int unsigned VW = VAW - OW;
  localparam int unsigned PW = PAW - OW;

  walk_st_e        st_q, st_d;
  logic [VAW-1:0]  va_q;
  logic            wr_q, sup_q;
  logic [AW-1:0]   addr_q, addr_calc;
  logic [PAW-1:0]  pa_q, pa_calc;
  fault_e          flt_q, flt_calc;
  logic            take, land, done;

  pte_addr_gen #(.VPN_W(VW), .AW(AW), .PTE_W(EW)) u_agen (
    .base_i (base_i),
    .vpn_i  (req_va_i[VAW-1:OW]),
    .addr_o (addr_calc)
  );

  pte_check #(.EW(EW), .PW(PW), .OW(OW)) u_chk (
    .pte_i   (mem_rdata_i),
    .write_i (wr_q),
    .sup_i   (sup_q),
    .off_i   (va_q[OW-1:0]),
    .fault_o (flt_calc),
    .pa_o    (pa_calc)
  );

  assign take = (st_q == ST_IDLE) && req_valid_i;
  assign land = (st_q == ST_WAIT) && mem_rvalid_i;
  assign done = (st_q == ST_RESP) && rsp_ready_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (take) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_WAIT;
      ST_WAIT:  if (land) st_d = ST_RESP;
      ST_RESP:  if (done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      wr_q   <= 1'b0;
      sup_q  <= 1'b0;
      addr_q <= '0;
      pa_q   <= '0;
      flt_q  <= FLT_OK;
    end else begin
      st_q <= st_d;
      if (take) begin
        va_q   <= req_va_i;
        wr_q   <= req_write_i;
        sup_q  <= req_sup_i;
        addr_q <= addr_calc;
      end
      if (land) begin
        pa_q  <= pa_calc;
        flt_q <= flt_calc;
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_FETCH);
  assign mem_addr_o  = addr_q;
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_pa_o    = pa_q;
  assign rsp_fault_o = flt_q;
  assign rsp_vpn_o   = va_q[VAW-1:OW];
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        mem_req_o,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [11:0] rsp_pa_o,
  input logic [1:0]  rsp_fault_o,
  input logic [7:0]  rsp_vpn_o
);
  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R2
  rsp_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  // R3
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R3
  rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (!req_ready_o && !rsp_valid_o));

  // R4
  fault_pa_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 2'b00) |-> (rsp_pa_o == 12'h000));

  // R6
  fault_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o != 2'b11));

  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o) && $stable(rsp_vpn_o)));

  // R9
  rsp_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i) |=> (!rsp_valid_o && req_ready_o));
endmodule

bind pt_walker pt_walker_chk u_pt_walker_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_pa_o    (rsp_pa_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_vpn_o   (rsp_vpn_o)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_sup = 1'b0;
  logic [15:0] base = 16'h0400;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [11:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic [7:0]  rsp_vpn;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned rd_cnt = 0;
  logic [15:0] last_addr = '0;
  logic [15:0] cur_pte = '0;
  int unsigned lat = 0;
  int unsigned wcnt = 0;
  logic        pend = 1'b0;
  logic        inject = 1'b0;

  always #4 clk = ~clk;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_write_i(req_write), .req_sup_i(req_sup),
    .base_i(base),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault), .rsp_vpn_o(rsp_vpn)
  );

  // memory model: one read in, data after lat+1 cycles
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      rd_cnt    <= rd_cnt + 1;
      last_addr <= mem_addr;
      pend      <= 1'b1;
      wcnt      <= lat;
    end else if (pend) begin
      if (wcnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= cur_pte;
        pend       <= 1'b0;
      end else begin
        wcnt <= wcnt - 1;
      end
    end
    if (inject) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= 16'h00FF;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_rsp(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  // one full walk; expects fault/pa; checks read count and address
  task automatic xlate(input logic [13:0] va, input logic wr, input logic sup,
                       input logic [15:0] pte, input logic [1:0] ef,
                       input logic [11:0] epa, input string tag);
    int unsigned rd0;
    bit got;
    logic [15:0] eaddr;
    eaddr = base + {7'd0, va[13:6], 1'b0};
    @(negedge clk);
    req_va = va; req_write = wr; req_sup = sup; cur_pte = pte;
    req_valid = 1'b1;
    rd0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
    wait_rsp(got);
    chk(got, {tag, " rsp seen"}, int'(got), 1);
    chk(rsp_fault == ef, {tag, " fault"}, int'(rsp_fault), int'(ef));
    chk(rsp_pa == epa, {tag, " pa"}, int'(rsp_pa), int'(epa));
    chk(rsp_vpn == va[13:6], "R4 vpn", int'(rsp_vpn), int'(va[13:6]));
    chk(rd_cnt == rd0 + 1, "R3 read count", int'(rd_cnt - rd0), 1);
    chk(last_addr == eaddr, "R3 entry address", int'(last_addr), int'(eaddr));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready == 1'b1, "R9 idle after handshake", int'(req_ready), 1);
  endtask

  // {va14, write, sup, pte16, fault2, pa12}; pte bits: [9]sup [8]wr [7]rd [6]present
  localparam int NV = 10;
  localparam logic [45:0] VEC [NV] = '{
    {14'h03D4, 1'b0, 1'b0, 16'h00CD, 2'b00, 12'h354},  // R8 read ok
    {14'h0B8F, 1'b0, 1'b0, 16'h0000, 2'b01, 12'h000},  // R4 absent
    {14'h0020, 1'b1, 1'b0, 16'h03E8, 2'b10, 12'h000},  // R5 user on sup page
    {14'h0020, 1'b1, 1'b1, 16'h03E8, 2'b00, 12'hA20},  // R5 sup allowed
    {14'h1FFF, 1'b1, 1'b0, 16'h00C5, 2'b10, 12'h000},  // R6 write to read-only
    {14'h1FFF, 1'b0, 1'b0, 16'h00C5, 2'b00, 12'h17F},  // R8 read same page
    {14'h2A41, 1'b0, 1'b1, 16'h0141, 2'b10, 12'h000},  // R6 read w/o read right
    {14'h0555, 1'b1, 1'b0, 16'h0388, 2'b01, 12'h000},  // R7 absent beats prot
    {14'h3FC0, 1'b0, 1'b0, 16'hFCFF, 2'b00, 12'hFC0},  // R11 upper bits ignored, top VPN
    {14'h0000, 1'b1, 1'b0, 16'h01C0, 2'b00, 12'h000}   // R8 VPN 0, ppn 0
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    bit got;
    int unsigned rd0;
    // R1 during and after reset
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1 in reset",
        int'({req_ready, rsp_valid, mem_req}), 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1 after reset",
        int'({req_ready, rsp_valid, mem_req}), 3'b100);

    for (int v = 0; v < NV; v++) begin
      logic [45:0] e;
      string tag;
      e = VEC[v];
      tag = (e[13:12] == 2'b00) ? "R8" : (e[13:12] == 2'b01) ? "R4" : "R6";
      lat = v % 3;
      xlate(e[45:32], e[31], e[30], e[29:14], e[13:12], e[11:0], tag);
    end

    // different base register
    base = 16'h1230;
    lat = 2;
    xlate(14'h0ABC, 1'b0, 1'b1, 16'h02D7, 2'b00, 12'h5FC, "R3 new base");

    // R7: absent with every permission set, user write
    xlate(14'h1111, 1'b1, 1'b0, 16'h03BF, 2'b01, 12'h000, "R7 all perms absent");

    // R10: stray read data in idle
    rd0 = rd_cnt;
    @(negedge clk); inject = 1'b1;
    @(negedge clk); inject = 1'b0;
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 no response from stray data", int'(rsp_valid), 0);
    chk(rd_cnt == rd0, "R10 no read from stray data", int'(rd_cnt - rd0), 0);
    chk(req_ready == 1'b1, "R10 still idle", int'(req_ready), 1);

    // R9 hold response; R2 request held high during walk and across handshake
    lat = 0;
    rd0 = rd_cnt;
    @(negedge clk);
    req_va = 14'h0240; req_write = 1'b0; req_sup = 1'b0; cur_pte = 16'h00C3;
    req_valid = 1'b1;
    wait_rsp(got);
    chk(got, "R9 rsp seen", int'(got), 1);
    chk(rd_cnt == rd0 + 1, "R2 single read while req held", int'(rd_cnt - rd0), 1);
    repeat (5) @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_pa == 12'h0C0 && rsp_fault == 2'b00,
        "R9 held response", int'(rsp_pa), 12'h0C0);
    chk(rd_cnt == rd0 + 1, "R2 no read while response pending", int'(rd_cnt - rd0), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R9 released",
        int'({req_ready, rsp_valid}), 2'b10);
    // request still high: taken at next edge, read one cycle later
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 back-to-back accept", int'(req_ready), 0);
    wait_rsp(got);
    chk(rd_cnt == rd0 + 2, "R3 second read", int'(rd_cnt - rd0), 2);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;

    // reset mid-walk returns to idle
    @(negedge clk);
    req_va = 14'h0100; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1 reset mid-walk",
        int'({req_ready, rsp_valid, mem_req}), 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule